// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block walks a circular ring of 32-bit codec command words held in system memory and hands each word, split into its fields, to a codec link. Software places commands in the ring, then moves the write pointer forward; the engine follows with its own read pointer. For each entry it issues one read on a simple request/response memory port and checks the returned word. If the word is legal, the engine presents its fields on a valid/ready command port.

Two conditions besides an empty ring hold the engine back. The first is a clear run bit. The second is the response side having reached its programmed count threshold. A separate immediate-command register lets software push one word past the ring. While its busy flag is set, that word goes out before any further ring entry, and the run bit does not gate it.

The engine acts only after a trigger. A trigger is a write to the write pointer, the control register or the immediate status register. Once the engine finds nothing it may do, it stays idle until the next trigger.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After synchronous reset, `rd_ptr` is 0, the run bit and the immediate busy flag are clear, and neither `mem_req_valid` nor `cmd_valid` is asserted.
- R2: When `rd_ptr` equals the 8-bit write pointer (register 2, bits 7:0), the ring is empty and no memory request is issued.
- R3: Before each fetch the read pointer increments modulo 256. The read address is the 64-bit base ({register 1, register 0}) plus 4 times the new pointer.
- R4: A fetched word is split into codec address = bits 31:28, node id = bits 26:20 and payload = bits 19:0, which appear on `cmd_cad`, `cmd_nid` and `cmd_payload`.
- R5: A word with bit 27 set (indirect node addressing) is discarded and never reaches the command port.
- R6: A word whose codec address has its bit clear in `codec_present` is discarded.
- R7: No ring fetch starts while the run bit (register 3, bit 0) is clear.
- R8: No ring fetch starts while `resp_count` equals the threshold (register 4, bits 7:0).
- R9: Writing 1 to register 6 bit 0 sets the immediate busy flag. While the flag is set, the word in register 5 is sent next, ahead of any ring entry and regardless of the run bit, with `cmd_imm` high. The flag clears once that word has been forwarded or discarded.
- R10: Fetching starts only after a write to register 2, 3 or 6. Once blocked, the engine stays idle even if the blocking condition goes away, until one of those registers is written again.
- R11: At most one command is in flight. `cmd_valid` and the command fields hold steady until `cmd_ready`, and no memory request is issued meanwhile.
- R12: The read pointer wraps from 255 to 0, and fetching continues across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| codec_present | input | 16 | One bit per codec address, set if a codec is attached |
| resp_count | input | 8 | Current count from the response side |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 64 | Byte address of the ring entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Decoded command valid |
| cmd_ready | input | 1 | Codec link accepts the command |
| cmd_cad | output | 4 | Codec address |
| cmd_nid | output | 7 | Node id |
| cmd_payload | output | 20 | Verb and payload bits |
| cmd_imm | output | 1 | Command came from the immediate path |
| rd_ptr | output | 8 | Current ring read pointer |
| imm_busy | output | 1 | Immediate command pending |

## Verification
The embedded properties check every cycle that a fetch starts only from a non-empty ring, with the run bit set, below the count threshold and with no immediate command waiting. They also check that each fetch steps the pointer by exactly one, and that a stalled command stays frozen while nothing else is fetched. Field extraction, the discarding of indirect and absent-codec words, the order of immediate versus ring commands, the sticky idle state after a block, and the pointer wrap depend on memory contents and software sequences. Only the bench scenarios, which compare the command stream against a scoreboard, can show those.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 64;
  localparam int CAD_W  = 4;
  localparam int NID_W  = 7;
  localparam int PAY_W  = 20;
  localparam int NUM_CAD = 1 << CAD_W;

  localparam logic [2:0] A_BASE_LO  = 3'd0;
  localparam logic [2:0] A_BASE_HI  = 3'd1;
  localparam logic [2:0] A_WR_PTR   = 3'd2;
  localparam logic [2:0] A_CTRL     = 3'd3;
  localparam logic [2:0] A_LIMIT    = 3'd4;
  localparam logic [2:0] A_IMM_WORD = 3'd5;
  localparam logic [2:0] A_IMM_STAT = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd1,
    S_WAIT = 3'd2,
    S_CHK  = 3'd3,
    S_SEND = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic [CAD_W-1:0] cad;
    logic             indirect;
    logic [NID_W-1:0] nid;
    logic [PAY_W-1:0] pay;
  } cmd_word_t;
endpackage

// File: rtl/crf_regs.sv
module crf_regs
  import crf_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              imm_done,
  output logic [ADDR_W-1:0] base,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              run,
  output logic [CNT_W-1:0]  resp_limit,
  output logic [WORD_W-1:0] imm_word,
  output logic              imm_busy,
  output logic              trigger
);
  logic [WORD_W-1:0] base_lo_q, base_hi_q;
  logic              set_busy;

  assign base = {base_hi_q, base_lo_q};

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo_q  <= '0;
      base_hi_q  <= '0;
      wr_ptr     <= '0;
      run        <= 1'b0;
      resp_limit <= '0;
      imm_word   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_BASE_LO:  base_lo_q  <= reg_wdata;
        A_BASE_HI:  base_hi_q  <= reg_wdata;
        A_WR_PTR:   wr_ptr     <= reg_wdata[PTR_W-1:0];
        A_CTRL:     run        <= reg_wdata[0];
        A_LIMIT:    resp_limit <= reg_wdata[CNT_W-1:0];
        A_IMM_WORD: imm_word   <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign set_busy = reg_we && (reg_addr == A_IMM_STAT) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst)           imm_busy <= 1'b0;
    else if (set_busy) imm_busy <= 1'b1;
    else if (imm_done) imm_busy <= 1'b0;
  end

  always_comb begin
    trigger = 1'b0;
    if (reg_we && (reg_addr == A_WR_PTR || reg_addr == A_CTRL ||
                   reg_addr == A_IMM_STAT))
      trigger = 1'b1;
  end

  p_busy_set_r9: assert property (@(posedge clk) disable iff (rst)
    set_busy |=> imm_busy);
endmodule

// File: rtl/crf_decode.sv
module crf_decode
  import crf_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  input  logic [NUM_CAD-1:0] codec_present,
  output logic [CAD_W-1:0]   cad,
  output logic [NID_W-1:0]   nid,
  output logic [PAY_W-1:0]   pay,
  output logic               fwd_ok
);
  cmd_word_t w;
  assign w   = cmd_word_t'(word);
  assign cad = w.cad;
  assign nid = w.nid;
  assign pay = w.pay;

  always_comb begin
    fwd_ok = 1'b1;
    if (w.indirect)           fwd_ok = 1'b0;
    if (!codec_present[w.cad]) fwd_ok = 1'b0;
  end
endmodule

// File: rtl/crf_seq.sv
module crf_seq
  import crf_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trigger,
  input  logic              run,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  resp_count,
  input  logic [CNT_W-1:0]  resp_limit,
  input  logic              imm_busy,
  input  logic [WORD_W-1:0] imm_word,
  output logic              imm_done,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic [WORD_W-1:0] word,
  input  logic              fwd_ok,
  input  logic [CAD_W-1:0]  dec_cad,
  input  logic [NID_W-1:0]  dec_nid,
  input  logic [PAY_W-1:0]  dec_pay,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CAD_W-1:0]  cmd_cad,
  output logic [NID_W-1:0]  cmd_nid,
  output logic [PAY_W-1:0]  cmd_payload,
  output logic              cmd_imm,
  output logic [PTR_W-1:0]  rd_ptr
);
  localparam int OFS_W = PTR_W + 2;

  seq_state_t       state;
  logic             kick_q;
  logic             src_imm_q;
  logic [PTR_W-1:0] rp_nxt;
  logic             empty, at_limit, blocked, idle;

  assign rp_nxt   = rd_ptr + 1'b1;
  assign empty    = (rd_ptr == wr_ptr);
  assign at_limit = (resp_count == resp_limit);
  assign idle     = (state == S_IDLE);
  assign blocked  = !imm_busy && (!run || empty || at_limit);
  assign imm_done = (state == S_CHK) && src_imm_q;

  always_ff @(posedge clk) begin
    if (rst) kick_q <= 1'b0;
    else     kick_q <= trigger | (kick_q & ~(idle & blocked));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      rd_ptr        <= '0;
      src_imm_q     <= 1'b0;
      word          <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      cmd_valid     <= 1'b0;
      cmd_cad       <= '0;
      cmd_nid       <= '0;
      cmd_payload   <= '0;
      cmd_imm       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (kick_q) begin
            if (imm_busy) begin
              word      <= imm_word;
              src_imm_q <= 1'b1;
              state     <= S_CHK;
            end else if (run && !empty && !at_limit) begin
              rd_ptr        <= rp_nxt;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= base + ADDR_W'({rp_nxt, 2'b00});
              src_imm_q     <= 1'b0;
              state         <= S_REQ;
            end
          end
        end
        S_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            word  <= mem_rsp_data;
            state <= S_CHK;
          end
        end
        S_CHK: begin
          if (fwd_ok) begin
            cmd_valid   <= 1'b1;
            cmd_cad     <= dec_cad;
            cmd_nid     <= dec_nid;
            cmd_payload <= dec_pay;
            cmd_imm     <= src_imm_q;
            state       <= S_SEND;
          end else begin
            state <= S_IDLE;
          end
        end
        S_SEND: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic unused_ofs;
  assign unused_ofs = (OFS_W == 0);

  p_no_fetch_empty_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> $past(rd_ptr != wr_ptr));
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> rd_ptr == PTR_W'($past(rd_ptr) + 1'b1));
  p_run_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> $past(run));
  p_limit_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> $past(resp_count != resp_limit));
  p_imm_first_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> !$past(imm_busy));
  p_hold_cmd_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid &&
      $stable({cmd_cad, cmd_nid, cmd_payload, cmd_imm}));
  p_single_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !mem_req_valid);
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import crf_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [2:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  input  logic [15:0]             codec_present,
  input  logic [CNT_W-1:0]        resp_count,
  output logic                    mem_req_valid,
  output logic [63:0]             mem_req_addr,
  input  logic                    mem_req_ready,
  input  logic                    mem_rsp_valid,
  input  logic [31:0]             mem_rsp_data,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [3:0]              cmd_cad,
  output logic [6:0]              cmd_nid,
  output logic [19:0]             cmd_payload,
  output logic                    cmd_imm,
  output logic [PTR_W-1:0]        rd_ptr,
  output logic                    imm_busy
);
  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  wr_ptr;
  logic              run, trigger, imm_done, fwd_ok;
  logic [CNT_W-1:0]  resp_limit;
  logic [WORD_W-1:0] imm_word, word;
  logic [CAD_W-1:0]  dec_cad;
  logic [NID_W-1:0]  dec_nid;
  logic [PAY_W-1:0]  dec_pay;

  crf_regs #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .imm_done(imm_done), .base(base),
    .wr_ptr(wr_ptr), .run(run), .resp_limit(resp_limit),
    .imm_word(imm_word), .imm_busy(imm_busy), .trigger(trigger)
  );

  crf_decode u_dec (
    .word(word), .codec_present(codec_present), .cad(dec_cad),
    .nid(dec_nid), .pay(dec_pay), .fwd_ok(fwd_ok)
  );

  crf_seq #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .trigger(trigger), .run(run), .wr_ptr(wr_ptr),
    .base(base), .resp_count(resp_count), .resp_limit(resp_limit),
    .imm_busy(imm_busy), .imm_word(imm_word), .imm_done(imm_done),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .word(word), .fwd_ok(fwd_ok),
    .dec_cad(dec_cad), .dec_nid(dec_nid), .dec_pay(dec_pay),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_cad(cmd_cad),
    .cmd_nid(cmd_nid), .cmd_payload(cmd_payload), .cmd_imm(cmd_imm),
    .rd_ptr(rd_ptr)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !cmd_valid && !mem_req_valid && rd_ptr == '0);
endmodule

// File: tb/tb_cmd_ring_fetch.sv
module tb_cmd_ring_fetch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [15:0] codec_present = 16'hFDFF;
  logic [7:0]  resp_count = '0;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [3:0]  cmd_cad;
  logic [6:0]  cmd_nid;
  logic [19:0] cmd_payload;
  logic        cmd_imm;
  logic [7:0]  rd_ptr;
  logic        imm_busy;

  cmd_ring_fetch dut (.*);

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int req_cnt = 0;
  int cyc = 0;
  logic [31:0] ring [256];
  logic [31:0] exp_q [$];
  logic [63:0] base_v = 64'h12345678_9ABC0000;
  logic [7:0]  model_ptr = 8'd0;
  logic        rdy_en = 1'b0;
  logic        stall_mode = 1'b0;
  logic        rsp_pend = 1'b0;
  logic [7:0]  rsp_idx = '0;

  function automatic logic [31:0] mkw(input logic [3:0] c, input logic ind,
                                      input logic [6:0] n, input logic [19:0] p);
    return {c, ind, n, p};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push_exp(input logic imm, input logic [31:0] w);
    exp_q.push_back({imm, w[31:28], w[26:20], w[19:0]});
  endtask

  task automatic drain();
    for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk("R4 scoreboard empty", 64'(exp_q.size()), 64'd0);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model and command monitor, all at the falling edge
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rsp_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = ring[rsp_idx];
      rsp_pend      = 1'b0;
    end
    if (mem_req_valid && mem_req_ready) begin
      model_ptr = model_ptr + 8'd1;
      req_cnt++;
      // R3 / R12: address is base plus four times the advanced pointer
      chk("R3 fetch address", mem_req_addr, base_v + {54'd0, model_ptr, 2'b00});
      rsp_idx  = mem_req_addr[9:2];
      rsp_pend = 1'b1;
    end
    cmd_ready = rdy_en && (!stall_mode || (cyc % 3 != 0));
    if (cmd_valid && cmd_ready) begin
      logic [31:0] got;
      got = {cmd_imm, cmd_cad, cmd_nid, cmd_payload};
      if (exp_q.size() == 0) chk("R4 unexpected command", {32'd0, got}, 64'hFFFF_FFFF_FFFF_FFFF);
      else chk("R4 command fields/order", {32'd0, got}, {32'd0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ring[i] = mkw(4'd1, 1'b0, 7'(i), 20'(i * 7 + 3));
    ring[1] = mkw(4'd0, 1'b0, 7'h11, 20'hABCDE);
    ring[2] = mkw(4'd3, 1'b0, 7'h7F, 20'h00001);
    ring[3] = mkw(4'd15, 1'b0, 7'h00, 20'hFFFFF);
    ring[4] = mkw(4'd2, 1'b1, 7'h05, 20'h12345);   // indirect
    ring[5] = mkw(4'd9, 1'b0, 7'h06, 20'h54321);   // absent codec
    ring[6] = mkw(4'd4, 1'b0, 7'h2A, 20'h0F0F0);
    ring[7] = mkw(4'd5, 1'b0, 7'h33, 20'h77777);
    ring[8] = mkw(4'd6, 1'b0, 7'h44, 20'h88888);
    ring[9] = mkw(4'd7, 1'b0, 7'h55, 20'h99999);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_ptr", 64'(rd_ptr), 0);
    chk("R1 cmd_valid", 64'(cmd_valid), 0);
    chk("R1 mem_req_valid", 64'(mem_req_valid), 0);
    chk("R1 imm_busy", 64'(imm_busy), 0);

    wr(3'd0, base_v[31:0]);
    wr(3'd1, base_v[63:32]);
    wr(3'd4, 32'd5);
    rdy_en = 1'b1;

    // R7: entries present but run clear
    wr(3'd2, 32'd3);
    repeat (20) @(negedge clk);
    chk("R7 no fetch with run clear", 64'(req_cnt), 0);

    // R2: run set with empty ring (wp==rp) first
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd1);
    repeat (20) @(negedge clk);
    chk("R2 no fetch on empty ring", 64'(req_cnt), 0);

    // R3/R4: three commands under back-pressure
    stall_mode = 1'b1;
    push_exp(1'b0, ring[1]); push_exp(1'b0, ring[2]); push_exp(1'b0, ring[3]);
    wr(3'd2, 32'd3);
    drain();
    chk("R3 rd_ptr after three", 64'(rd_ptr), 3);
    stall_mode = 1'b0;

    // R5/R6: indirect and absent-codec words dropped
    push_exp(1'b0, ring[6]);
    wr(3'd2, 32'd6);
    drain();
    chk("R5 R6 rd_ptr past dropped", 64'(rd_ptr), 6);
    chk("R5 R6 fetch count", 64'(req_cnt), 6);

    // R8: count threshold reached blocks fetch
    @(negedge clk); resp_count = 8'd5;
    wr(3'd2, 32'd7);
    repeat (20) @(negedge clk);
    chk("R8 no fetch at threshold", 64'(rd_ptr), 6);
    // R10: unblocking alone does not resume
    @(negedge clk); resp_count = 8'd0;
    repeat (20) @(negedge clk);
    chk("R10 idle until trigger", 64'(req_cnt), 6);
    push_exp(1'b0, ring[7]);
    wr(3'd3, 32'd1);
    drain();
    chk("R10 resumed after trigger", 64'(rd_ptr), 7);

    // R9 / R11: immediate word overtakes a pending ring entry
    rdy_en = 1'b0;
    push_exp(1'b0, ring[8]);
    wr(3'd2, 32'd8);
    repeat (15) @(negedge clk);
    chk("R11 held command valid", 64'(cmd_valid), 1);
    chk("R11 no fetch while held", 64'(req_cnt), 8);
    wr(3'd5, mkw(4'd2, 1'b0, 7'h1C, 20'hC0FFE));
    wr(3'd6, 32'd1);
    chk("R9 busy set", 64'(imm_busy), 1);
    push_exp(1'b1, mkw(4'd2, 1'b0, 7'h1C, 20'hC0FFE));
    push_exp(1'b0, ring[9]);
    wr(3'd2, 32'd9);
    rdy_en = 1'b1;
    drain();
    chk("R9 busy cleared", 64'(imm_busy), 0);

    // R9: immediate with run clear still goes out; dropped immediate clears busy
    wr(3'd3, 32'd0);
    wr(3'd5, mkw(4'd8, 1'b0, 7'h01, 20'h00042));
    push_exp(1'b1, mkw(4'd8, 1'b0, 7'h01, 20'h00042));
    wr(3'd6, 32'd1);
    drain();
    wr(3'd5, mkw(4'd9, 1'b0, 7'h01, 20'h00043));
    wr(3'd6, 32'd1);
    repeat (10) @(negedge clk);
    chk("R9 dropped immediate clears busy", 64'(imm_busy), 0);

    // R12: long run across the wrap
    for (int i = 10; i < 256; i++) push_exp(1'b0, ring[i]);
    for (int i = 0; i < 3; i++) push_exp(1'b0, ring[i]);
    wr(3'd2, 32'd2);
    wr(3'd3, 32'd1);
    drain();
    chk("R12 rd_ptr after wrap", 64'(rd_ptr), 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule